// File: doc/BRIEF.md
# Byte-Lane Data Memory

This block is a word-wide scratch memory that is addressed in bytes. A two-bit access code, qualified by an enable, selects one of four operations: a full-word read, a single-byte write, a halfword write or a full-word write. A partial write changes only the byte lanes it addresses. Every other byte of the word keeps its value.

The block takes an alignment rule from the access size. A word access needs a byte address that is a multiple of four. A halfword write needs a multiple of two. A byte write may use any address. An access that breaks its rule raises an error output in the same cycle, and no storage changes. Writes take effect on the rising clock edge. Reads are combinational from the word index, so a word written at one edge can be read in the cycle that follows.

The storage depth is a parameter and must be a power of two. Address bits above the word index are not decoded. An active-low reset clears every word to zero.

Top module: `bytemem_top`

## Requirements
- R1: While reset is asserted, and after reset is released, every word reads as zero until it is written.
- R2: With `mem_en` low, no storage changes, `rd_word` is zero and `misalign` is low, whatever the other inputs are.
- R3: With `mem_en` high, `op` = 2'b00 and `addr[1:0]` = 0, `rd_word` shows the stored word at the current word index in the same cycle. In every other case `rd_word` is zero.
- R4: `op` = 2'b01 writes `wr_word[7:0]` into the lane chosen by `addr[1:0]`. Lane k is bits 8k+7:8k, in little-endian order. The other three lanes are unchanged, and `misalign` stays low for any address.
- R5: `op` = 2'b10 with `addr[0]` = 0 writes `wr_word[15:0]` into bits 15:0 when `addr[1]` = 0, or into bits 31:16 when `addr[1]` = 1. The other half is unchanged.
- R6: `op` = 2'b11 with `addr[1:0]` = 0 replaces the whole word with `wr_word`.
- R7: A word read or word write with `addr[1:0]` ≠ 0, or a halfword write with `addr[0]` = 1, drives `misalign` high in that cycle and changes no byte of storage.
- R8: The word index is `addr[IDX_W+1:2]`, where IDX_W = log2(DEPTH). Address bits above the index are ignored, so addresses that differ only there reach the same word.
- R9: A write takes effect at the rising clock edge. A read in the next cycle returns the new data. A word that receives no write keeps its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes on the rising edge |
| rst_n | input | 1 | Active-low reset; clears all storage |
| mem_en | input | 1 | Qualifies every access |
| op | input | 2 | 00 word read, 01 byte write, 10 halfword write, 11 word write |
| addr | input | ADDR_W | Byte address |
| wr_word | input | 32 | Write data, right-aligned for partial writes |
| rd_word | output | 32 | Read data; zero unless an aligned word read is active |
| misalign | output | 1 | High while the access breaks its alignment rule |

## Verification
The assertions assume that `op`, `addr` and `mem_en` are stable across the sampling edge and have known values once reset is released. They also assume that a repeated read of one address has no write between the two reads. The stimulus changes inputs only on the falling clock edge. It never leaves an input undriven after reset. The stability property only fires when two consecutive cycles are reads. Random traffic uses every `op` value and lands on both aligned and misaligned addresses. High address bits are randomised so that aliasing addresses are exercised.

// File: rtl/bytemem_pkg.sv
package bytemem_pkg;

   typedef enum logic [1:0] {
      OP_RD_WORD = 2'b00,
      OP_WR_BYTE = 2'b01,
      OP_WR_HALF = 2'b10,
      OP_WR_WORD = 2'b11
   } mem_op_e;

   localparam int unsigned WORD_W  = 32;
   localparam int unsigned LANE_W  = 8;
   localparam int unsigned N_LANES = WORD_W / LANE_W;

endpackage

// File: rtl/bytemem_decode.sv
module bytemem_decode
   import bytemem_pkg::*;
(
   input  logic                 en,
   input  logic [1:0]           op,
   input  logic [1:0]           low_addr,
   output logic [N_LANES-1:0]   lane_we,
   output logic                 rd_act,
   output logic                 bad_align
);

   logic aligned;
   logic [N_LANES-1:0] mask;

   always_comb begin
      aligned = 1'b1;
      mask    = '0;
      unique case (mem_op_e'(op))
         OP_RD_WORD: begin
            aligned = (low_addr == 2'b00);
         end
         OP_WR_BYTE: begin
            mask[low_addr] = 1'b1;
         end
         OP_WR_HALF: begin
            aligned = ~low_addr[0];
            mask    = low_addr[1] ? 4'b1100 : 4'b0011;
         end
         OP_WR_WORD: begin
            aligned = (low_addr == 2'b00);
            mask    = 4'b1111;
         end
         default: begin
            aligned = 1'b1;
            mask    = '0;
         end
      endcase
   end

   assign bad_align = en & ~aligned;
   assign lane_we   = (en & aligned) ? mask : '0;
   assign rd_act    = en & aligned & (op == OP_RD_WORD);

endmodule

// File: rtl/bytemem_steer.sv
module bytemem_steer
   import bytemem_pkg::*;
(
   input  logic [1:0]        op,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] lanes
);

   always_comb begin
      unique case (mem_op_e'(op))
         OP_WR_BYTE: lanes = {N_LANES{din[LANE_W-1:0]}};
         OP_WR_HALF: lanes = {2{din[2*LANE_W-1:0]}};
         default:    lanes = din;
      endcase
   end

endmodule

// File: rtl/bytemem_store.sv
module bytemem_store
   import bytemem_pkg::*;
#(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [IDX_W-1:0]   idx,
   input  logic [N_LANES-1:0] lane_we,
   input  logic [WORD_W-1:0]  lanes,
   output logic [WORD_W-1:0]  word_q
);

   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
         end else if (lane_we[g]) begin
            cells[idx] <= lanes[g*LANE_W +: LANE_W];
         end
      end

      assign word_q[g*LANE_W +: LANE_W] = cells[idx];
   end

endmodule

// File: rtl/bytemem_top.sv
module bytemem_top
   import bytemem_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DEPTH  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_en,
   input  logic [1:0]        op,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wr_word,
   output logic [31:0]       rd_word,
   output logic              misalign
);

   localparam int unsigned IDX_W = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("bytemem_top: DEPTH must be a power of two of at least 2");
   end
   if (ADDR_W < IDX_W + 2) begin : g_bad_addr
      $error("bytemem_top: ADDR_W too narrow for DEPTH");
   end
   if (WORD_W != 32) begin : g_bad_word
      $error("bytemem_top: word width must be 32");
   end

   logic [N_LANES-1:0] lane_we;
   logic               rd_act;
   logic [WORD_W-1:0]  lanes;
   logic [WORD_W-1:0]  word_q;
   logic [IDX_W-1:0]   idx;

   assign idx = addr[IDX_W+1:2];

   bytemem_decode u_dec (
      .en        (mem_en),
      .op        (op),
      .low_addr  (addr[1:0]),
      .lane_we   (lane_we),
      .rd_act    (rd_act),
      .bad_align (misalign)
   );

   bytemem_steer u_steer (
      .op    (op),
      .din   (wr_word),
      .lanes (lanes)
   );

   bytemem_store #(.DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx     (idx),
      .lane_we (lane_we),
      .lanes   (lanes),
      .word_q  (word_q)
   );

   assign rd_word = rd_act ? word_q : '0;

endmodule

// File: rtl/bytemem_chk.sv
module bytemem_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_en,
   input logic [1:0]        op,
   input logic [ADDR_W-1:0] addr,
   input logic [31:0]       rd_word,
   input logic              misalign
);

   logic seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_en |-> (rd_word == 32'h0 && !misalign));

   assert_nonread_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && op != 2'b00) |-> rd_word == 32'h0);

   assert_byte_never_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && op == 2'b01) |-> !misalign);

   assert_half_odd_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && op == 2'b10 && addr[0]) |-> misalign);

   assert_word_unaligned_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && (op == 2'b00 || op == 2'b11) && addr[1:0] != 2'b00) |-> misalign);

   assert_read_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && mem_en && op == 2'b00 && $past(mem_en) && $past(op) == 2'b00
       && addr == $past(addr)) |-> rd_word == $past(rd_word));

endmodule

bind bytemem_top bytemem_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mem_en   (mem_en),
   .op       (op),
   .addr     (addr),
   .rd_word  (rd_word),
   .misalign (misalign)
);

// File: tb/tb_bytemem_top.sv
module tb_bytemem_top;

   localparam int ADDR_W = 32;
   localparam int DEPTH  = 64;
   localparam int IDX_W  = $clog2(DEPTH);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              mem_en = 1'b0;
   logic [1:0]        op = 2'b00;
   logic [ADDR_W-1:0] addr = '0;
   logic [31:0]       wr_word = '0;
   logic [31:0]       rd_word;
   logic              misalign;

   int vectors = 0;
   int fails   = 0;
   logic [31:0] model [DEPTH];

   always #5 clk = ~clk;

   bytemem_top #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .op(op), .addr(addr),
      .wr_word(wr_word), .rd_word(rd_word), .misalign(misalign)
   );

   function automatic string tag_of(logic e, logic [1:0] o, logic [1:0] lo);
      if (!e) return "R2";
      if ((o == 2'b00 || o == 2'b11) && lo != 2'b00) return "R7";
      if (o == 2'b10 && lo[0]) return "R7";
      case (o)
         2'b00:   return "R3";
         2'b01:   return "R4";
         2'b10:   return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic step(input logic e, input logic [1:0] o,
                       input logic [ADDR_W-1:0] a, input logic [31:0] d,
                       input string why);
      int          ix;
      logic        bad;
      logic [31:0] exp_rd;
      logic [31:0] w;
      @(negedge clk);
      mem_en = e; op = o; addr = a; wr_word = d;
      #1;
      ix  = int'(a[IDX_W+1:2]);
      bad = e && (((o == 2'b00 || o == 2'b11) && a[1:0] != 2'b00) ||
                  (o == 2'b10 && a[0]));
      exp_rd = (e && o == 2'b00 && !bad) ? model[ix] : 32'h0;
      vectors++;
      if (rd_word !== exp_rd || misalign !== bad) begin
         fails++;
         $display("FAIL %s: rd_word=%h misalign=%b expected rd_word=%h misalign=%b",
                  why, rd_word, misalign, exp_rd, bad);
      end
      @(posedge clk);
      if (e && !bad) begin
         w = model[ix];
         case (o)
            2'b01: w[8*a[1:0] +: 8] = d[7:0];
            2'b10: w[16*a[1] +: 16] = d[15:0];
            2'b11: w = d;
            default: ;
         endcase
         model[ix] = w;
      end
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, input string why);
      step(1'b1, 2'b00, a, 32'hDEAD_0000, why);
   endtask

   initial begin
      #200_000_0;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) model[i] = 32'h0;
      repeat (3) @(posedge clk);
      #1;
      vectors++;
      if (rd_word !== 32'h0 || misalign !== 1'b0) begin
         fails++;
         $display("FAIL R1: in reset rd_word=%h misalign=%b expected 0 0", rd_word, misalign);
      end
      @(negedge clk);
      rst_n = 1'b1;
      // R1: every word reads zero after reset
      for (int i = 0; i < DEPTH; i++) rd(ADDR_W'(i * 4), "R1");
      // R6 / R9: word write then read next cycle
      step(1'b1, 2'b11, 32'h0000_0010, 32'hCAFE_F00D, "R6");
      rd(32'h0000_0010, "R9");
      // R4: each lane of a word
      step(1'b1, 2'b11, 32'h0000_0020, 32'h1122_3344, "R6");
      for (int l = 0; l < 4; l++) begin
         step(1'b1, 2'b01, ADDR_W'(32 + l), 32'hFFFF_FFA0 + l, "R4");
         rd(32'h0000_0020, "R4");
      end
      // R5: both halves, then odd address
      step(1'b1, 2'b10, 32'h0000_0030, 32'hAAAA_5555, "R5");
      step(1'b1, 2'b10, 32'h0000_0032, 32'h0000_BEEF, "R5");
      rd(32'h0000_0030, "R5");
      step(1'b1, 2'b10, 32'h0000_0031, 32'h1234_5678, "R7");
      rd(32'h0000_0030, "R7");
      // R7: misaligned word write and read
      step(1'b1, 2'b11, 32'h0000_0013, 32'h0BAD_0BAD, "R7");
      step(1'b1, 2'b00, 32'h0000_0012, 32'h0, "R7");
      rd(32'h0000_0010, "R7");
      // R2: disabled writes have no effect
      step(1'b0, 2'b11, 32'h0000_0010, 32'hFFFF_FFFF, "R2");
      step(1'b0, 2'b01, 32'h0000_0011, 32'hFFFF_FFFF, "R2");
      step(1'b0, 2'b00, 32'h0000_0010, 32'h0, "R2");
      rd(32'h0000_0010, "R2");
      // R8: high bits alias onto the same word
      step(1'b1, 2'b11, 32'hF000_0104, 32'h5A5A_A5A5, "R8");
      rd(32'h0000_0004, "R8");
      rd(32'h7700_0204, "R8");
      // random traffic
      for (int n = 0; n < 3000; n++) begin
         logic [ADDR_W-1:0] a;
         logic [1:0] o;
         logic e;
         a = $urandom;
         if ($urandom_range(0, 3) != 0) a[1:0] = 2'b00;
         o = 2'($urandom);
         e = ($urandom_range(0, 7) != 0);
         step(e, o, a, $urandom, tag_of(e, o, a[1:0]));
      end
      // R9: every word keeps its value
      for (int i = 0; i < DEPTH; i++) rd(ADDR_W'(i * 4), "R9");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule